// File: doc/BRIEF.md
# Timer Channel Event Request Router

This block is one capture/compare channel of a small timer. It includes the free-running counter and prescaler that give the channel its time base. A channel event sets a sticky status flag. The event is either an edge on the capture input or the counter stepping onto a programmed compare value. Two independent enables route that flag:

- the interrupt enable drives an interrupt line;
- the DMA enable drives a DMA transfer request.

Software clears the flag by writing a one to it. While DMA routing is on, the DMA engine's completion pulse also clears it.

Configuration arrives through a plain synchronous write port: enable, a two-bit address, and a data word. The counter value, the last captured value, the channel output and its drive enable are brought out so the channel can be observed.

Top module: `tmr_chan_router`

## Requirements
- R1: A write (wr_en high at a rising clk) stores fields as follows. Address 0 (control): clock mode in bits [1:0], prescale select in bits [4:2], overflow-interrupt enable in bit 5, and overflow-flag clear in bit 7. Address 1 (channel): flag clear in bit 0, interrupt enable in bit 1, DMA enable in bit 2, mode in bit 3 (0 capture, 1 compare), and edge/level select in bits [5:4]. Address 2 holds the compare value.
- R2: After reset the following all read zero: count, cap_value, chan_out, pin_oe, dma_req, chan_irq and ovf_irq. The clock mode is 00, so the counter stays stopped. The channel is in capture mode with edge/level select 00.
- R3: With a non-zero clock mode, the counter advances by one (wrapping) once every 2^prescale clocks. With clock mode 00, both the counter and the prescaler hold.
- R4: In capture mode, edge/level select picks the capture edge: 01 rising, 10 falling, 11 either, 00 none. A selected edge on cap_in sets the flag one clock later. On that same clock, cap_value takes the count seen in the cycle of the edge.
- R5: With DMA enable 0 and interrupt enable 0, dma_req and chan_irq stay low whatever the flag holds.
- R6: With interrupt enable 1 and DMA enable 0, chan_irq equals the flag and dma_req stays low.
- R7: With DMA enable 1 and interrupt enable 0, dma_req equals the flag and chan_irq stays low.
- R8: With both enables 1, dma_req and chan_irq both equal the flag.
- R9: With DMA enable 0, only a channel write with bit 0 set clears the flag. A channel write with bit 0 clear leaves it, and a dma_done pulse leaves it.
- R10: With DMA enable 1, the flag clears on a dma_done pulse or on a channel write with bit 0 set.
- R11: A channel event in the same cycle as either clear wins: the flag is set afterwards.
- R12: A counter step from all ones to zero sets an overflow flag. ovf_irq equals that flag ANDed with the overflow-interrupt enable. A control write with bit 7 set clears the flag, and a wrap in the same cycle wins over the clear.
- R13: In compare mode, a counter step onto the compare value sets the flag and acts on chan_out according to edge/level select: 01 toggle, 10 drive low, 11 drive high. pin_oe is high only in compare mode with a non-zero edge/level select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Register write data |
| cap_in | input | 1 | Capture input, already synchronous to clk |
| dma_done | input | 1 | DMA transfer-complete pulse |
| dma_req | output | 1 | DMA transfer request |
| chan_irq | output | 1 | Channel interrupt |
| ovf_irq | output | 1 | Counter overflow interrupt |
| count | output | CNT_W | Counter value |
| cap_value | output | CNT_W | Last captured counter value |
| chan_out | output | 1 | Compare output level |
| pin_oe | output | 1 | Channel output drive enable |

## Verification
The bench builds the block with DATA_W=8, CNT_W=8 and PS_W=3. With these values the counter wraps within 256 clocks at the fastest prescale. Overflow flags and compare matches therefore occur many times inside a short run, and every prescale divisor up to 128 is reachable. A random phase then writes all three registers, including clock-mode changes mid-count. It also lands capture edges and dma_done pulses on clear cycles, which exercises the event-over-clear priority and the DMA-enable gate of the done pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CHAN = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;

    // control word layout (prescale width is a parameter of the users)
    localparam int CT_CMODE_LSB = 0;
    localparam int CT_PS_LSB    = 2;

    // channel word layout
    localparam int CH_FLAG_BIT = 0;
    localparam int CH_IE_BIT   = 1;
    localparam int CH_DMA_BIT  = 2;
    localparam int CH_MODE_BIT = 3;
    localparam int CH_ELS_LSB  = 4;

    typedef enum logic {
        CH_CAPTURE = 1'b0,
        CH_COMPARE = 1'b1
    } ch_mode_e;

    typedef enum logic [1:0] {
        ELS_OFF = 2'b00,
        ELS_A   = 2'b01,
        ELS_B   = 2'b10,
        ELS_AB  = 2'b11
    } els_e;

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        cmode,
    output logic [PS_W-1:0]   ps_sel,
    output logic              ovf_ie,
    output logic              ovf_clr,
    output logic              ch_ie,
    output logic              ch_dma_en,
    output ch_mode_e          ch_mode,
    output els_e              ch_els,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              flag_clr
);

    localparam int OVF_IE_BIT  = CT_PS_LSB + PS_W;
    localparam int OVF_CLR_BIT = DATA_W - 1;

    typedef struct packed {
        logic [1:0]       cmode;
        logic [PS_W-1:0]  ps;
        logic             ovf_ie;
        logic             ie;
        logic             dma;
        ch_mode_e         mode;
        els_e             els;
        logic [CNT_W-1:0] cmp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ctrl, wr_chan, wr_cmp;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_chan = wr_en && (wr_addr == ADDR_CHAN);
    assign wr_cmp  = wr_en && (wr_addr == ADDR_CMP);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.cmode  = wr_data[CT_CMODE_LSB +: 2];
            cfg_d.ps     = wr_data[CT_PS_LSB +: PS_W];
            cfg_d.ovf_ie = wr_data[OVF_IE_BIT];
        end
        if (wr_chan) begin
            cfg_d.ie   = wr_data[CH_IE_BIT];
            cfg_d.dma  = wr_data[CH_DMA_BIT];
            cfg_d.mode = ch_mode_e'(wr_data[CH_MODE_BIT]);
            cfg_d.els  = els_e'(wr_data[CH_ELS_LSB +: 2]);
        end
        if (wr_cmp) begin
            cfg_d.cmp = wr_data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // clear strobes act in the write cycle itself
    assign ovf_clr   = wr_ctrl && wr_data[OVF_CLR_BIT];
    assign flag_clr  = wr_chan && wr_data[CH_FLAG_BIT];

    assign cmode     = cfg_q.cmode;
    assign ps_sel    = cfg_q.ps;
    assign ovf_ie    = cfg_q.ovf_ie;
    assign ch_ie     = cfg_q.ie;
    assign ch_dma_en = cfg_q.dma;
    assign ch_mode   = cfg_q.mode;
    assign ch_els    = cfg_q.els;
    assign cmp_val   = cfg_q.cmp;

endmodule

// File: rtl/tmr_prescale_count.sv
module tmr_prescale_count #(
    parameter int CNT_W = 8,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmode,
    input  logic [PS_W-1:0]  ps_sel,
    input  logic             ovf_ie,
    input  logic             ovf_clr,
    output logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             ovf_irq
);

    localparam int               PRE_W   = (1 << PS_W) - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic             run;
    logic             tick_c;
    logic             wrap;
    logic [PRE_W-1:0] pre_lim;
    logic [CNT_W-1:0] cnt_step;

    always_comb begin
        run      = (cmode != 2'b00);
        pre_lim  = (PRE_W'(1) << ps_sel) - PRE_W'(1);
        // ">=" keeps a shrunk divisor from running the prescaler around
        tick_c   = run && (st_q.pre >= pre_lim);
        cnt_step = st_q.cnt + 1'b1;
        wrap     = tick_c && (st_q.cnt == CNT_MAX);

        st_d = st_q;
        if (run) begin
            st_d.pre = tick_c ? '0 : st_q.pre + 1'b1;
        end
        if (tick_c) begin
            st_d.cnt = cnt_step;
        end
        st_d.ovf = wrap | (st_q.ovf & ~ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick    = tick_c;
    assign count   = st_q.cnt;
    assign cnt_nxt = cnt_step;
    assign ovf_irq = st_q.ovf & ovf_ie;

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode == 2'b00) |=> $stable(count)); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == CNT_W'($past(count) + 1'b1))); // R3

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == CNT_MAX) |=> st_q.ovf); // R12

endmodule

// File: rtl/tmr_chan_unit.sv
module tmr_chan_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  ch_mode_e         mode,
    input  els_e             els,
    input  logic             ie,
    input  logic             dma_en,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             flag_clr,
    input  logic             dma_done,
    output logic             dma_req,
    output logic             chan_irq,
    output logic [CNT_W-1:0] cap_value,
    output logic             chan_out,
    output logic             pin_oe
);

    typedef struct packed {
        logic             prev;
        logic             flag;
        logic [CNT_W-1:0] cap;
        logic             out;
    } ch_st_t;

    ch_st_t     st_d, st_q;
    logic [1:0] els_bits;
    logic       rise, fall;
    logic       cap_evt, cmp_evt, evt, clr;

    always_comb begin
        els_bits = els;
        rise     = cap_in & ~st_q.prev;
        fall     = ~cap_in & st_q.prev;
        cap_evt  = (mode == CH_CAPTURE) &&
                   ((els_bits[0] && rise) || (els_bits[1] && fall));
        cmp_evt  = (mode == CH_COMPARE) && tick && (cnt_nxt == cmp_val);
        evt      = cap_evt | cmp_evt;
        // completion pulse only counts while DMA routing is on
        clr      = flag_clr | (dma_done & dma_en);

        st_d      = st_q;
        st_d.prev = cap_in;
        st_d.flag = evt | (st_q.flag & ~clr);
        if (cap_evt) begin
            st_d.cap = cnt_q;
        end
        if (cmp_evt) begin
            case (els)
                ELS_A:   st_d.out = ~st_q.out;
                ELS_B:   st_d.out = 1'b0;
                ELS_AB:  st_d.out = 1'b1;
                default: st_d.out = st_q.out;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dma_req   = st_q.flag & dma_en;
    assign chan_irq  = st_q.flag & ie;
    assign cap_value = st_q.cap;
    assign chan_out  = st_q.out;
    assign pin_oe    = (mode == CH_COMPARE) && (els != ELS_OFF);

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> st_q.flag); // R11

    AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !dma_en && !flag_clr) |=> st_q.flag); // R9

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && dma_en && dma_done && !evt) |=> !st_q.flag); // R10

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_value == $past(cnt_q))); // R4

endmodule

// File: rtl/tmr_chan_router.sv
module tmr_chan_router
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_in,
    input  logic              dma_done,
    output logic              dma_req,
    output logic              chan_irq,
    output logic              ovf_irq,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cap_value,
    output logic              chan_out,
    output logic              pin_oe
);

    logic [1:0]       cmode;
    logic [PS_W-1:0]  ps_sel;
    logic             ovf_ie, ovf_clr;
    logic             ch_ie, ch_dma_en, flag_clr;
    ch_mode_e         ch_mode;
    els_e             ch_els;
    logic [CNT_W-1:0] cmp_val;
    logic             tick;
    logic [CNT_W-1:0] cnt_nxt;

    tmr_cfg_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .PS_W   (PS_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmode     (cmode),
        .ps_sel    (ps_sel),
        .ovf_ie    (ovf_ie),
        .ovf_clr   (ovf_clr),
        .ch_ie     (ch_ie),
        .ch_dma_en (ch_dma_en),
        .ch_mode   (ch_mode),
        .ch_els    (ch_els),
        .cmp_val   (cmp_val),
        .flag_clr  (flag_clr)
    );

    tmr_prescale_count #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmode   (cmode),
        .ps_sel  (ps_sel),
        .ovf_ie  (ovf_ie),
        .ovf_clr (ovf_clr),
        .tick    (tick),
        .count   (count),
        .cnt_nxt (cnt_nxt),
        .ovf_irq (ovf_irq)
    );

    tmr_chan_unit #(
        .CNT_W (CNT_W)
    ) chan_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_in    (cap_in),
        .mode      (ch_mode),
        .els       (ch_els),
        .ie        (ch_ie),
        .dma_en    (ch_dma_en),
        .cmp_val   (cmp_val),
        .tick      (tick),
        .cnt_q     (count),
        .cnt_nxt   (cnt_nxt),
        .flag_clr  (flag_clr),
        .dma_done  (dma_done),
        .dma_req   (dma_req),
        .chan_irq  (chan_irq),
        .cap_value (cap_value),
        .chan_out  (chan_out),
        .pin_oe    (pin_oe)
    );

endmodule

// File: tb/tmr_chan_router_tb.sv
module tmr_chan_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = 8;
    localparam int PS_W       = 3;
    localparam int CNT_MOD    = 1 << CNT_W;
    localparam int WD_CYCLES  = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              cap_in = 1'b0;
    logic              dma_done = 1'b0;
    logic              dma_req, chan_irq, ovf_irq, chan_out, pin_oe;
    logic [CNT_W-1:0]  count, cap_value;

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_chan_router #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_in(cap_in), .dma_done(dma_done),
        .dma_req(dma_req), .chan_irq(chan_irq), .ovf_irq(ovf_irq),
        .count(count), .cap_value(cap_value), .chan_out(chan_out),
        .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cmode, m_ps, m_oie, m_ovf;
    int m_ie, m_dma, m_mode, m_els, m_cmp;
    int m_pre, m_cnt, m_flag, m_cap, m_out, m_prev;

    always @(posedge clk) begin
        int lim, ncnt, ev, clr, oclr;
        bit tk, rise, fall;
        if (!rst_n) begin
            m_cmode = 0; m_ps = 0; m_oie = 0; m_ovf = 0;
            m_ie = 0; m_dma = 0; m_mode = 0; m_els = 0; m_cmp = 0;
            m_pre = 0; m_cnt = 0; m_flag = 0; m_cap = 0; m_out = 0; m_prev = 0;
        end else begin
            lim  = (1 << m_ps) - 1;
            tk   = (m_cmode != 0) && (m_pre >= lim);
            ncnt = (m_cnt + 1) % CNT_MOD;
            rise = cap_in && !m_prev;
            fall = !cap_in && m_prev;
            ev = 0;
            if (m_mode == 0 && (((m_els & 1) != 0 && rise) || ((m_els & 2) != 0 && fall))) begin
                ev = 1;
                m_cap = m_cnt;
            end
            if (m_mode == 1 && tk && ncnt == m_cmp) begin
                ev = 1;
                if (m_els == 1) m_out = 1 - m_out;
                else if (m_els == 2) m_out = 0;
                else if (m_els == 3) m_out = 1;
            end
            clr  = (wr_en && wr_addr == 2'd1 && wr_data[0]) || (dma_done && m_dma == 1);
            oclr = wr_en && wr_addr == 2'd0 && wr_data[7];
            if (ev) m_flag = 1; else if (clr) m_flag = 0;
            if (tk && m_cnt == CNT_MOD - 1) m_ovf = 1; else if (oclr) m_ovf = 0;
            if (m_cmode != 0) m_pre = tk ? 0 : m_pre + 1;
            if (tk) m_cnt = ncnt;
            m_prev = cap_in;
            if (wr_en && wr_addr == 2'd0) begin
                m_cmode = wr_data[1:0]; m_ps = wr_data[4:2]; m_oie = wr_data[5];
            end
            if (wr_en && wr_addr == 2'd1) begin
                m_ie = wr_data[1]; m_dma = wr_data[2]; m_mode = wr_data[3]; m_els = wr_data[5:4];
            end
            if (wr_en && wr_addr == 2'd2) m_cmp = wr_data;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R3 count",      count,     m_cnt);
            chk("R4 cap_value",  cap_value, m_cap);
            chk("R7 dma_req",    dma_req,   m_flag & m_dma);
            chk("R6 chan_irq",   chan_irq,  m_flag & m_ie);
            chk("R12 ovf_irq",   ovf_irq,   m_ovf & m_oie);
            chk("R13 chan_out",  chan_out,  m_out);
            chk("R13 pin_oe",    pin_oe,    (m_mode == 1 && m_els != 0) ? 1 : 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cap_pulse();
        @(negedge clk); cap_in = 1'b1;
        @(negedge clk); cap_in = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int c0;
        logic prev_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        chk("R2 count", count, 0);      chk("R2 cap_value", cap_value, 0);
        chk("R2 dma_req", dma_req, 0);  chk("R2 chan_irq", chan_irq, 0);
        chk("R2 ovf_irq", ovf_irq, 0);  chk("R2 chan_out", chan_out, 0);
        chk("R2 pin_oe", pin_oe, 0);
        cmp_on = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 counter stopped", count, 0);

        // R3: run at full rate
        wr(2'd0, 8'h01);
        c0 = count;
        @(negedge clk);
        chk("R3 step per clock", count, (c0 + 1) % CNT_MOD);
        wr(2'd0, 8'h09);               // prescale 2 -> divide by 4
        repeat (20) @(negedge clk);
        wr(2'd0, 8'h01);

        // R5: capture on rising edge, no routing
        wr(2'd1, 8'h10);
        cap_pulse();
        chk("R5 no dma_req", dma_req, 0);
        chk("R5 no chan_irq", chan_irq, 0);
        // R6: enable interrupt only; flag was kept
        wr(2'd1, 8'h12);
        chk("R6 chan_irq", chan_irq, 1);
        chk("R6 no dma_req", dma_req, 0);
        // R9: done ignored, zero write ignored, one write clears
        done_pulse();
        chk("R9 done ignored", chan_irq, 1);
        wr(2'd1, 8'h12);
        chk("R9 zero write ignored", chan_irq, 1);
        wr(2'd1, 8'h13);
        chk("R9 one write clears", chan_irq, 0);

        // R7 and R10
        wr(2'd1, 8'h14);
        cap_pulse();
        chk("R7 dma_req", dma_req, 1);
        chk("R7 no chan_irq", chan_irq, 0);
        done_pulse();
        chk("R10 done clears", dma_req, 0);

        // R8 and R10 through a write
        wr(2'd1, 8'h16);
        cap_pulse();
        chk("R8 dma_req", dma_req, 1);
        chk("R8 chan_irq", chan_irq, 1);
        wr(2'd1, 8'h17);
        chk("R10 write clears", dma_req, 0);

        // R11: event coincides with write clear, then with done
        @(negedge clk);
        cap_in = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h17;
        @(negedge clk);
        wr_en = 1'b0; cap_in = 1'b0;
        chk("R11 event beats write clear", dma_req, 1);
        @(negedge clk);
        cap_in = 1'b1; dma_done = 1'b1;
        @(negedge clk);
        cap_in = 1'b0; dma_done = 1'b0;
        chk("R11 event beats done", dma_req, 1);
        wr(2'd1, 8'h17);

        // R4: falling edge select
        wr(2'd1, 8'h26);
        @(negedge clk); cap_in = 1'b1;
        @(negedge clk);
        chk("R4 rise ignored on falling select", chan_irq, 0);
        cap_in = 1'b0;
        @(negedge clk);
        chk("R4 falling edge sets flag", chan_irq, 1);
        wr(2'd1, 8'h37);               // both edges, clear
        cap_pulse();
        chk("R4 either edge sets flag", chan_irq, 1);
        wr(2'd1, 8'h07);               // select off, clear
        cap_pulse();
        chk("R4 select off no event", chan_irq, 0);

        // R12: overflow
        wr(2'd0, 8'hA0);               // stop, enable, clear
        chk("R12 cleared", ovf_irq, 0);
        wr(2'd0, 8'h21);
        for (int i = 0; i < 600 && !ovf_irq; i++) @(negedge clk);
        chk("R12 overflow raised", ovf_irq, 1);
        wr(2'd0, 8'hA1);

        // R13: compare toggle
        wr(2'd2, 8'd50);
        wr(2'd1, 8'h1B);
        chk("R1 compare field drives pin_oe", pin_oe, 1);
        prev_out = chan_out;
        for (int i = 0; i < 600 && !chan_irq; i++) begin
            prev_out = chan_out;
            @(negedge clk);
        end
        chk("R13 match flag", chan_irq, 1);
        chk("R13 toggle", chan_out, !prev_out);
        chk("R13 match count", count, 50);
        wr(2'd1, 8'h3B);               // drive high on match
        for (int i = 0; i < 600 && !chan_irq; i++) @(negedge clk);
        chk("R13 set high", chan_out, 1);

        // R3: stop holds
        wr(2'd0, 8'h00);
        c0 = count;
        repeat (10) @(negedge clk);
        chk("R3 stop holds", count, c0);

        // random phase against the model
        wr(2'd0, 8'h21);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(3) == 0) cap_in = ~cap_in;
            dma_done = ($urandom_range(7) == 0);
            wr_en    = ($urandom_range(11) == 0);
            wr_addr  = 2'($urandom_range(2));
            wr_data  = 8'($urandom);
            if (wr_en && wr_addr == 2'd0 && $urandom_range(1) == 0) wr_data[4:2] = 3'd0;
        end
        @(negedge clk);
        wr_en = 1'b0; dma_done = 1'b0;
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule